// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-lane SPI master controlled through a small memory-mapped register set on a 32-bit read/write bus. Software sets up a command word with clock mode, chip-select choice, chip-select handling, direction enables and a bit length. It loads a word into a one-entry transmit port and sets the start bit. The block then shifts out 1 to 32 bits MSB first, on a serial clock divided down from the system clock. At the same time it gathers the bits arriving on MISO into a one-entry receive port.

Completion shows as a sticky ready flag that software clears by writing 1 to it. A status register combines live full/empty indications for both ports with sticky overflow and underrun flags and their OR. The chip-select lines can be held low by software across several words, or driven by the shifter for the length of one transfer.

Top module: `spi_reg_master`

## Requirements
- R1: After reset all four chip selects are high, SCLK and MOSI are low, the command register reads 0x0030_0000 (software chip-select on, value 1), transfer status reads 0, and FIFO status reads 0x0000_0005 (bit 2 TX empty and bit 0 RX empty).
- R2: Registers: command 0x000, clock divider 0x008, transfer status 0x010, FIFO status 0x014, block count 0x024 (16 bits stored, upper bits read 0), TX port 0x108 (write only), RX port 0x188. Every other address, and any read of the TX port, returns 0.
- R3: Writing the command register with bit 31 set while idle starts a transfer of (bits 4:0)+1 bits. The transfer lasts 2·bits·(div+1) clock cycles, with SCLK toggling every div+1 cycles. Command bit 31 reads 1 for exactly that time.
- R4: Command bits 29:28 give the clock mode {polarity, phase}. SCLK idles at the polarity value. With phase 0, data is sampled on the first (leading) edge of each bit. With phase 1, it is sampled on the second (trailing) edge.
- R5: With command bit 21 set, the chip select picked by bits 27:26 follows bit 20 (0 = low/active). With bit 21 clear, that line is low only while a transfer runs. Unselected lines stay high, and never more than one line is low.
- R6: Transfer status bit 30 sets when the last bit has been shifted, stays set, and clears on a write with bit 30 = 1.
- R7: TX data is right-justified and sent MSB first, starting at bit (length−1). The RX word holds the last received bit in bit 0, with bits above the length zero. MOSI is low outside a transfer.
- R8: With command bit 12 (receive enable) clear, the RX port is not written. With bit 11 (transmit enable) clear, MOSI stays low and the TX port keeps its content.
- R9: A TX port write while it holds unsent data sets FIFO status bit 7 and discards the new word.
- R10: A start with transmit enabled and the TX port empty sets FIFO status bit 6 and shifts zeros.
- R11: Reading an empty RX port returns 0 and sets bit 4. Capturing into a full RX port sets bit 5 and keeps the newer word.
- R12: FIFO status bits 7:4 clear on a write of 1 to them. Bit 8 is their OR. Bits 3/2 are TX full/empty and bits 1/0 are RX full/empty.
- R13: Command register writes that arrive while a transfer runs are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| bus_ready | output | 1 | Access completes in the same cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that the bus carries at most one access per cycle and that MISO is steady around the system clock edge that samples it. They also assume that the divider is not rewritten during a transfer, since the block does not guard that register. The stimulus drives the bus and MISO only on the falling system clock edge. It changes the divider only while the shifter is idle. Each MISO bit is held across its whole serial bit window, so either sampling edge sees the intended value.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 5;

  localparam int unsigned OFS_CMD   = 'h000;
  localparam int unsigned OFS_DIV   = 'h008;
  localparam int unsigned OFS_XSTAT = 'h010;
  localparam int unsigned OFS_FSTAT = 'h014;
  localparam int unsigned OFS_BLK   = 'h024;
  localparam int unsigned OFS_TXP   = 'h108;
  localparam int unsigned OFS_RXP   = 'h188;

  localparam int unsigned BIT_GO    = 31;
  localparam int unsigned BIT_RDY   = 30;

  typedef struct packed {
    logic [1:0]       mode;    // {polarity, phase}
    logic [1:0]       cs_sel;
    logic             sw_cs;
    logic             cs_val;
    logic             rx_en;
    logic             tx_en;
    logic [LEN_W-1:0] len_m1;
  } cmd_t;

  typedef struct packed {
    logic tx_ovf;
    logic tx_unr;
    logic rx_ovf;
    logic rx_unr;
  } sticky_t;

  // Command word as seen by software; bit 31 mirrors the busy shifter.
  function automatic logic [DATA_W-1:0] cmd_word(cmd_t c, logic busy);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[31]    = busy;
    w[29:28] = c.mode;
    w[27:26] = c.cs_sel;
    w[21]    = c.sw_cs;
    w[20]    = c.cs_val;
    w[12]    = c.rx_en;
    w[11]    = c.tx_en;
    w[4:0]   = c.len_m1;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] fstat_word(sticky_t s, logic tx_full, logic rx_full);
    logic [DATA_W-1:0] w;
    w      = '0;
    w[8]   = |s;
    w[7:4] = s;
    w[3]   = tx_full;
    w[2]   = ~tx_full;
    w[1]   = rx_full;
    w[0]   = ~rx_full;
    return w;
  endfunction

  // Moves bit (len_m1) of a right-justified word up to the MSB.
  function automatic logic [DATA_W-1:0] align_msb(logic [DATA_W-1:0] w, logic [LEN_W-1:0] len_m1);
    return w << (LEN_W'(DATA_W - 1) - len_m1);
  endfunction
endpackage

// File: rtl/spi_rm_divider.sv
module spi_rm_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter
  import spi_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk_lvl,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              done
);
  localparam int unsigned EDGE_W = LEN_W + 1;

  logic [EDGE_W-1:0] edge_q;
  logic [LEN_W-1:0]  lm1_q;
  logic              cpha_q;
  logic [DATA_W-1:0] txsr_q;
  logic [DATA_W-1:0] rxsr_q;
  logic [DATA_W-1:0] aligned;
  logic              leading;
  logic              sample_edge;
  logic              last_edge;

  assign aligned     = align_msb(tx_word, len_m1);
  assign leading     = ~edge_q[0];
  assign sample_edge = cpha_q ? ~leading : leading;
  assign last_edge   = (edge_q == {lm1_q, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sclk_lvl <= 1'b0;
      mosi     <= 1'b0;
      edge_q   <= '0;
      lm1_q    <= '0;
      cpha_q   <= 1'b0;
      txsr_q   <= '0;
      rxsr_q   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        sclk_lvl <= 1'b0;
        edge_q   <= '0;
        lm1_q    <= len_m1;
        cpha_q   <= cpha;
        rxsr_q   <= '0;
        if (!cpha) begin
          mosi   <= aligned[DATA_W-1];
          txsr_q <= aligned << 1;
        end else begin
          mosi   <= 1'b0;
          txsr_q <= aligned;
        end
      end else if (busy && tick) begin
        sclk_lvl <= ~sclk_lvl;
        edge_q   <= edge_q + 1'b1;
        if (sample_edge) begin
          rxsr_q <= {rxsr_q[DATA_W-2:0], miso};
        end else if (!last_edge) begin
          mosi   <= txsr_q[DATA_W-1];
          txsr_q <= txsr_q << 1;
        end
        if (last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
          mosi <= 1'b0;
        end
      end
    end
  end

  assign rx_word = rxsr_q;
endmodule

// File: rtl/spi_rm_csdrive.sv
module spi_rm_csdrive #(
  parameter int unsigned NCS = 4,
  localparam int unsigned SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             sw_ctl,
  input  logic             sw_val,
  input  logic             busy,
  output logic [NCS-1:0]   cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    logic hit;
    assign hit     = (sel == SEL_W'(i));
    assign cs_n[i] = !hit ? 1'b1 : (sw_ctl ? sw_val : ~busy);
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_rm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned NCS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NCS-1:0]    spi_cs_n
);
  localparam int unsigned SEL_W = (NCS > 1) ? $clog2(NCS) : 1;

  cmd_t              cmd_q;
  logic [DIV_W-1:0]  div_q;
  logic [BLK_W-1:0]  blk_q;
  logic              ready_q;
  logic [DATA_W-1:0] tx_q;
  logic              tx_full;
  logic [DATA_W-1:0] rx_q;
  logic              rx_full;
  sticky_t           sticky_q;

  logic              busy;
  logic              tick;
  logic              sclk_lvl;
  logic              done_evt;
  logic [DATA_W-1:0] rx_word;

  // Named bus events
  logic wr_evt, rd_evt;
  logic cmd_wr, start_evt, tx_wr, rx_rd, xstat_wr, fstat_wr, div_wr, blk_wr;
  logic tx_ovf_evt, tx_unr_evt, rx_unr_evt, rx_ovf_evt, tx_take;
  logic [DATA_W-1:0] shift_word;

  assign wr_evt     = bus_req && bus_we;
  assign rd_evt     = bus_req && !bus_we;
  assign cmd_wr     = wr_evt && (bus_addr == ADDR_W'(OFS_CMD)) && !busy;
  assign start_evt  = cmd_wr && bus_wdata[BIT_GO];
  assign div_wr     = wr_evt && (bus_addr == ADDR_W'(OFS_DIV));
  assign xstat_wr   = wr_evt && (bus_addr == ADDR_W'(OFS_XSTAT));
  assign fstat_wr   = wr_evt && (bus_addr == ADDR_W'(OFS_FSTAT));
  assign blk_wr     = wr_evt && (bus_addr == ADDR_W'(OFS_BLK));
  assign tx_wr      = wr_evt && (bus_addr == ADDR_W'(OFS_TXP));
  assign rx_rd      = rd_evt && (bus_addr == ADDR_W'(OFS_RXP));

  assign tx_take    = start_evt && bus_wdata[11];
  assign tx_ovf_evt = tx_wr && tx_full;
  assign tx_unr_evt = tx_take && !tx_full;
  assign rx_unr_evt = rx_rd && !rx_full;
  assign rx_ovf_evt = done_evt && cmd_q.rx_en && rx_full && !rx_rd;
  assign shift_word = (tx_take && tx_full) ? tx_q : '0;

  spi_rm_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (div_q),
    .tick  (tick)
  );

  spi_rm_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .len_m1   (bus_wdata[4:0]),
    .cpha     (bus_wdata[28]),
    .tx_word  (shift_word),
    .tick     (tick),
    .miso     (spi_miso),
    .busy     (busy),
    .sclk_lvl (sclk_lvl),
    .mosi     (spi_mosi),
    .rx_word  (rx_word),
    .done     (done_evt)
  );

  spi_rm_csdrive #(.NCS(NCS)) u_cs (
    .sel    (SEL_W'(cmd_q.cs_sel)),
    .sw_ctl (cmd_q.sw_cs),
    .sw_val (cmd_q.cs_val),
    .busy   (busy),
    .cs_n   (spi_cs_n)
  );

  assign spi_sclk = sclk_lvl ^ cmd_q.mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '{mode: 2'd0, cs_sel: 2'd0, sw_cs: 1'b1, cs_val: 1'b1,
                    rx_en: 1'b0, tx_en: 1'b0, len_m1: '0};
      div_q    <= '0;
      blk_q    <= '0;
      ready_q  <= 1'b0;
      tx_q     <= '0;
      tx_full  <= 1'b0;
      rx_q     <= '0;
      rx_full  <= 1'b0;
      sticky_q <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_q <= '{mode: bus_wdata[29:28], cs_sel: bus_wdata[27:26],
                   sw_cs: bus_wdata[21], cs_val: bus_wdata[20],
                   rx_en: bus_wdata[12], tx_en: bus_wdata[11],
                   len_m1: bus_wdata[4:0]};
      end
      if (div_wr) div_q <= bus_wdata[DIV_W-1:0];
      if (blk_wr) blk_q <= bus_wdata[BLK_W-1:0];

      if (done_evt) ready_q <= 1'b1;
      else if (xstat_wr && bus_wdata[BIT_RDY]) ready_q <= 1'b0;

      // TX port
      if (tx_take) begin
        tx_full <= 1'b0;
      end else if (tx_wr && !tx_full) begin
        tx_q    <= bus_wdata;
        tx_full <= 1'b1;
      end

      // RX port: capture at completion takes priority over a read
      if (rx_rd && rx_full) rx_full <= 1'b0;
      if (done_evt && cmd_q.rx_en) begin
        rx_q    <= rx_word;
        rx_full <= 1'b1;
      end

      // Sticky flags: set beats write-one-to-clear
      sticky_q.tx_ovf <= tx_ovf_evt | (sticky_q.tx_ovf & ~(fstat_wr & bus_wdata[7]));
      sticky_q.tx_unr <= tx_unr_evt | (sticky_q.tx_unr & ~(fstat_wr & bus_wdata[6]));
      sticky_q.rx_ovf <= rx_ovf_evt | (sticky_q.rx_ovf & ~(fstat_wr & bus_wdata[5]));
      sticky_q.rx_unr <= rx_unr_evt | (sticky_q.rx_unr & ~(fstat_wr & bus_wdata[4]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_evt) begin
      unique case (bus_addr)
        ADDR_W'(OFS_CMD):   bus_rdata = cmd_word(cmd_q, busy);
        ADDR_W'(OFS_DIV):   bus_rdata = 32'(div_q);
        ADDR_W'(OFS_XSTAT): bus_rdata = 32'(ready_q) << BIT_RDY;
        ADDR_W'(OFS_FSTAT): bus_rdata = fstat_word(sticky_q, tx_full, rx_full);
        ADDR_W'(OFS_BLK):   bus_rdata = 32'(blk_q);
        ADDR_W'(OFS_RXP):   bus_rdata = rx_full ? rx_q : '0;
        default:            bus_rdata = '0;
      endcase
    end
  end

  assign bus_ready = bus_req;
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk #(
  parameter int unsigned NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           tick,
  input logic           done_evt,
  input logic           start_evt,
  input logic           bus_req,
  input logic           bus_we,
  input logic [11:0]    bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [12:0]    cmd_bits,
  input logic           cpol,
  input logic           tx_full,
  input logic           tx_unr,
  input logic           spi_sclk,
  input logic           spi_mosi,
  input logic [NCS-1:0] spi_cs_n
);
  // R3: the divider only produces edges inside a transfer
  a_r3_tick_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);

  // R3: an accepted start makes the shifter busy
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R4: serial clock rests at the polarity level between transfers
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cpol));

  // R5: at most one chip select active
  a_r5_one_cs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  // R6: completion coincides with the shifter going idle
  a_r6_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_evt);

  // R7: MOSI is low outside a transfer
  a_r7_mosi_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_mosi);

  // R10: start with transmit enabled and nothing loaded flags underrun
  a_r10_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && bus_wdata[11] && !tx_full) |=> tx_unr);

  // R13: command writes during a transfer leave the fields unchanged
  a_r13_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_req && bus_we && bus_addr == 12'h000) |=> $stable(cmd_bits));
endmodule

bind spi_reg_master spi_reg_master_chk #(.NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .tick      (tick),
  .done_evt  (done_evt),
  .start_evt (start_evt),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cmd_bits  (cmd_q),
  .cpol      (cmd_q.mode[1]),
  .tx_full   (tx_full),
  .tx_unr    (sticky_q.tx_unr),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/spi_reg_master_tb.sv
`timescale 1ns/1ps
module spi_reg_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  function automatic logic [31:0] mk(input int mode, input int sel, input bit sw, input bit val,
                                     input bit rx, input bit tx, input int lm1, input bit go);
    return {go, 1'b0, 2'(mode), 2'(sel), 4'b0, sw, val, 7'b0, rx, tx, 6'b0, 5'(lm1)};
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          m_active = 0;
  int          m_k = 0, m_lenc = 0, m_len = 0, m_div = 0, m_sel = 0;
  bit          m_sw = 1, m_val = 1, m_cpol = 0, m_cpha = 0;
  logic [31:0] m_txw = '0, m_pat = '0;
  logic [31:0] m_txsrc = '0, m_patsrc = '0;

  always @(posedge clk) begin
    bit was;
    if (!rst_n) begin
      m_active = 0; m_div = 0; m_sw = 1; m_val = 1; m_sel = 0; m_cpol = 0; m_cpha = 0;
    end else begin
      was = m_active;
      if (m_active) begin
        if (m_k == m_lenc - 1) m_active = 0;
        else m_k++;
      end
      if (req && we && addr == 12'h000 && !was) begin
        m_cpol = wdata[29]; m_cpha = wdata[28]; m_sel = int'(wdata[27:26]);
        m_sw = wdata[21]; m_val = wdata[20]; m_len = int'(wdata[4:0]);
        if (wdata[31]) begin
          m_active = 1; m_k = 0;
          m_lenc = 2 * (m_len + 1) * (m_div + 1);
          m_txw = wdata[11] ? m_txsrc : 32'h0;
          m_pat = m_patsrc;
        end
      end
      if (req && we && addr == 12'h008) m_div = int'(wdata[7:0]);
    end
  end

  // Per-clock comparison of the serial pins, and MISO drive
  always @(negedge clk) begin
    logic [3:0] e_cs;
    logic       e_sclk, e_mosi;
    int         h;
    if (rst_n && !finished) begin
      e_cs = 4'hF;
      if (m_sw) e_cs[m_sel] = m_val;
      else if (m_active) e_cs[m_sel] = 1'b0;
      if (m_active) begin
        h = m_k / (m_div + 1);
        e_sclk = m_cpol ^ h[0];
        if (!m_cpha) e_mosi = m_txw[m_len - h / 2];
        else e_mosi = (h == 0) ? 1'b0 : m_txw[m_len - (h - 1) / 2];
        miso = m_pat[m_len - h / 2];
      end else begin
        e_sclk = m_cpol;
        e_mosi = 1'b0;
        miso = 1'b0;
      end
      check("R5", "cs_n", 32'(cs_n), 32'(e_cs));
      check("R3/R4", "sclk", 32'(sclk), 32'(e_sclk));
      check("R7", "mosi", 32'(mosi), 32'(e_mosi));
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (m_active);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1", "cs_n", 32'(cs_n), 32'hF);
    check("R1", "sclk", 32'(sclk), 0);
    rd(12'h014, d); check("R1", "fifo status", d, 32'h5);
    rd(12'h010, d); check("R1", "xfer status", d, 32'h0);
    rd(12'h000, d); check("R1", "command", d, 32'h0030_0000);

    // R2 map
    wr(12'h024, 32'hABCD_1234);
    rd(12'h024, d); check("R2", "block count", d, 32'h0000_1234);
    rd(12'h020, d); check("R2", "unmapped 0x020", d, 0);
    rd(12'h004, d); check("R2", "unmapped 0x004", d, 0);
    wr(12'h108, 32'h0000_00A5);
    rd(12'h108, d); check("R2", "tx port read", d, 0);

    // Mode 0, 8 bits, div 1, software CS low on line 0
    wr(12'h008, 32'd1);
    rd(12'h008, d); check("R2", "divider", d, 32'd1);
    m_txsrc = 32'hA5; m_patsrc = 32'h3C;
    wr(12'h000, mk(0, 0, 1, 0, 1, 1, 7, 1));
    rd(12'h000, d); check("R3", "busy bit", d, mk(0, 0, 1, 0, 1, 1, 7, 1));
    wait_idle();
    rd(12'h000, d); check("R3", "busy cleared", d, mk(0, 0, 1, 0, 1, 1, 7, 0));
    rd(12'h010, d); check("R6", "ready set", d, 32'h4000_0000);
    rd(12'h010, d); check("R6", "ready sticky", d, 32'h4000_0000);
    wr(12'h010, 32'h4000_0000);
    rd(12'h010, d); check("R6", "ready cleared", d, 0);
    rd(12'h014, d); check("R12", "rx full tx empty", d, 32'h6);
    rd(12'h188, d); check("R7", "rx 8 bit", d, 32'h3C);
    rd(12'h014, d); check("R12", "ports empty", d, 32'h5);

    // Mode 3, 16 bits, div 2, line 2
    wr(12'h008, 32'd2);
    m_txsrc = 32'h1234; m_patsrc = 32'hFFFF_BEEF;
    wr(12'h108, 32'h1234);
    wr(12'h000, mk(3, 2, 1, 0, 1, 1, 15, 1));
    wait_idle();
    rd(12'h188, d); check("R4", "rx mode 3", d, 32'hBEEF);

    // Mode 1, 32 bits, div 0, line 1
    wr(12'h008, 32'd0);
    m_txsrc = 32'hDEAD_BEEF; m_patsrc = 32'h1357_9BDF;
    wr(12'h108, 32'hDEAD_BEEF);
    wr(12'h000, mk(1, 1, 1, 0, 1, 1, 31, 1));
    wait_idle();
    rd(12'h188, d); check("R4", "rx mode 1 32 bit", d, 32'h1357_9BDF);

    // Mode 2, single bit, line 3
    m_txsrc = 32'h1; m_patsrc = 32'hFFFF_FFFF;
    wr(12'h108, 32'h1);
    wr(12'h000, mk(2, 3, 1, 0, 1, 1, 0, 1));
    wait_idle();
    rd(12'h188, d); check("R7", "rx 1 bit", d, 32'h1);

    // Hardware chip select on line 1
    wr(12'h000, mk(0, 1, 0, 0, 1, 1, 3, 0));
    check("R5", "hw cs idle", 32'(cs_n), 32'hF);
    m_txsrc = 32'hA; m_patsrc = 32'h5;
    wr(12'h108, 32'hA);
    wr(12'h000, mk(0, 1, 0, 0, 1, 1, 3, 1));
    wait_idle();
    rd(12'h188, d); check("R5", "rx hw cs", d, 32'h5);
    check("R5", "hw cs after", 32'(cs_n), 32'hF);

    // R13 command write ignored during a transfer
    wr(12'h008, 32'd3);
    m_txsrc = 32'h0F0F_0F0F; m_patsrc = 32'h8000_0001;
    wr(12'h108, 32'h0F0F_0F0F);
    wr(12'h000, mk(0, 0, 1, 0, 1, 1, 31, 1));
    repeat (10) @(negedge clk);
    wr(12'h000, mk(3, 3, 1, 1, 0, 0, 2, 1));
    wait_idle();
    rd(12'h000, d); check("R13", "command unchanged", d, mk(0, 0, 1, 0, 1, 1, 31, 0));
    rd(12'h188, d); check("R13", "rx after ignored write", d, 32'h8000_0001);
    wr(12'h008, 32'd0);

    // R9 TX overflow, R8 rx disabled
    wr(12'h108, 32'h11);
    wr(12'h108, 32'h22);
    rd(12'h014, d); check("R9", "tx overflow", d, 32'h189);
    m_txsrc = 32'h11; m_patsrc = 32'hFF;
    wr(12'h000, mk(0, 0, 1, 0, 0, 1, 7, 1));
    wait_idle();
    rd(12'h014, d); check("R8", "rx disabled no capture", d, 32'h185);
    wr(12'h014, 32'h80);
    rd(12'h014, d); check("R12", "overflow cleared", d, 32'h5);

    // R10 TX underrun
    m_txsrc = 32'h0; m_patsrc = 32'h0;
    wr(12'h000, mk(0, 0, 1, 0, 0, 1, 7, 1));
    wait_idle();
    rd(12'h014, d); check("R10", "tx underrun", d, 32'h145);
    wr(12'h014, 32'h40);

    // R8 transmit disabled: port untouched, MOSI low
    wr(12'h108, 32'h77);
    m_patsrc = 32'hC3;
    wr(12'h000, mk(0, 0, 1, 0, 1, 0, 7, 1));
    wait_idle();
    rd(12'h014, d); check("R8", "tx kept rx full", d, 32'hA);

    // R11 RX overflow then underrun
    m_txsrc = 32'h77; m_patsrc = 32'h5A;
    wr(12'h000, mk(0, 0, 1, 0, 1, 1, 7, 1));
    wait_idle();
    rd(12'h014, d); check("R11", "rx overflow", d, 32'h126);
    rd(12'h188, d); check("R11", "newest kept", d, 32'h5A);
    rd(12'h188, d); check("R11", "empty read zero", d, 0);
    rd(12'h014, d); check("R11", "rx underrun", d, 32'h135);
    wr(12'h014, 32'h30);
    rd(12'h014, d); check("R12", "sticky cleared", d, 32'h5);

    wr(12'h000, mk(0, 0, 1, 1, 0, 0, 7, 0));
    check("R5", "cs released", 32'(cs_n), 32'hF);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule